// File: doc/BRIEF.md
# PCI Bridge Window Map Register Bank

This block holds the eight 32-bit control words of a PCI host bridge and uses them to turn accesses into three memory windows into 32-bit PCI memory addresses. Software reaches the words through a simple word-wide register port. Each window has a translation port: a byte offset into the window goes in, and the matching PCI address comes out in the same cycle, together with a flag for offsets that fall outside the window.

A static `mode_sel` input picks how a window's map word becomes its PCI base. In shifted-nibble mode (`mode_sel`=0) the low four bits of the map word become address bits 31:28. In masked mode (`mode_sel`=1) the map word is cleared below the window size, so only the bits above the size take effect. Each mode has its own set of window sizes, given as parameters. The secondary map words, the identity word and the flags word are storage only and do not affect translation.

The register port is control traffic and uses plain strobes, with no back-pressure. A read is accepted in every cycle in which `reg_rd` is high. Its data comes back one cycle later, marked by `reg_rvalid`. The translation ports are combinational and have no handshake, because a result is produced in every cycle and nothing can stall.

Top module: `pci_win_map`

## Requirements
- R1: After reset all eight words read zero, so every window translates an in-range offset to the offset itself.
- R2: The words sit at these byte offsets: 0x00, 0x04 and 0x08 are map words 0 to 2; 0x0C is the identity word; 0x10 is the flags word; 0x14, 0x18 and 0x1C are secondary map words 0 to 2. A word-wide write stores all 32 bits, and a later read returns them unchanged.
- R3: A read strobe in cycle n gives `reg_rvalid`=1 and the data in cycle n+1. `reg_rvalid` is 0 after a cycle with no read. `reg_rdata` holds its value between reads.
- R4: A read at any other offset, including one whose two low bits are not zero, returns zero. A write at such an offset changes no word.
- R5: With `mode_sel`=0, the window address is {map[3:0], 28'h0} + offset. Map bits 31:4 are ignored.
- R6: With `mode_sel`=1, the window address is (map AND NOT(size−1)) + offset.
- R7: `win_oor[i]` is 1 exactly when offset ≥ size(i). The default sizes are 0x0C000000, 0x10000000 and 0x10000000 in mode 0, and 0x01000000, 0x04000000 and 0x08000000 in mode 1. The address is not defined while the flag is set.
- R8: A write to map word i changes window i's translation from the cycle after the write. Writes to the secondary map, identity or flags words change no translation.
- R9: When a read and a write to the same offset are strobed in the same cycle, the read returns the value held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_sel | input | 1 | Translation scheme: 0 = shifted nibble, 1 = masked; static |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_addr | input | ADDR_W | Byte offset of the word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid when reg_rvalid is high |
| reg_rvalid | output | 1 | Read data valid |
| win_off | input | NWIN×32 | Offset into each window |
| win_addr | output | NWIN×32 | Translated PCI address of each window |
| win_oor | output | NWIN | Offset at or beyond the window size |

## Verification
The embedded properties check, on every cycle, the one-cycle read return, the zero read and untouched words for undefined offsets, the top nibble in mode 0, the preserved high base bits in mode 1, and that writes to non-map words leave the translations unchanged. The bench's scenarios are the only place where exact read-back values, the reset contents, the exact sums at window boundaries, the flag at size−1 against size, the read-before-write order and the effect of changing the mode across a reset are shown. For these, a behavioural model is compared against every output on every cycle.

// File: rtl/pci_win_map_pkg.sv
package pci_win_map_pkg;
  localparam int NWIN   = 3;
  localparam int NWORD  = 8;
  localparam int IDX_W  = $clog2(NWORD);
  // word indices inside the bank (byte offset = index * 4)
  localparam int IDX_MAP0 = 0;
  localparam int IDX_SELF = 3;
  localparam int IDX_FLG  = 4;
  localparam int IDX_SEC0 = 5;

  typedef logic [31:0] word_t;

  typedef struct packed {
    logic             hit;
    logic [IDX_W-1:0] idx;
  } dec_t;

  function automatic dec_t decode_off(input logic [31:0] a);
    dec_t d;
    d.idx = a[IDX_W+1:2];
    d.hit = (a[1:0] == 2'b00) && (a < 32'(NWORD * 4));
    return d;
  endfunction
endpackage

// File: rtl/pci_win_regbank.sv
module pci_win_regbank
  import pci_win_map_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr,
  input  logic                   rd,
  input  logic [ADDR_W-1:0]      addr,
  input  logic [31:0]            wdata,
  output logic [31:0]            rdata,
  output logic                   rvalid,
  output logic [NWIN-1:0][31:0]  map_q
);
  logic [NWORD-1:0][31:0] words_q;
  dec_t dec;

  always_comb dec = decode_off(32'(addr));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      words_q <= '0;
      rdata   <= '0;
      rvalid  <= 1'b0;
    end else begin
      rvalid <= rd;
      if (rd) rdata <= dec.hit ? words_q[dec.idx] : 32'h0;
      if (wr && dec.hit) words_q[dec.idx] <= wdata;
    end
  end

  for (genvar g = 0; g < NWIN; g++) begin : g_map
    assign map_q[g] = words_q[IDX_MAP0 + g];
  end

  // R3
  rd_then_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd |=> rvalid);
  // R4
  undef_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && !dec.hit) |=> (rdata == 32'h0));
  // R4
  undef_write_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !dec.hit) |=> $stable(words_q));
endmodule

// File: rtl/pci_win_xlate.sv
module pci_win_xlate #(
  parameter logic [31:0] SIZE_NIB = 32'h1000_0000,
  parameter logic [31:0] SIZE_MSK = 32'h0100_0000
) (
  input  logic        mode_sel,
  input  logic [31:0] map_word,
  input  logic [31:0] off,
  output logic [31:0] addr,
  output logic        oor
);
  logic [31:0] size, base;

  always_comb begin
    size = mode_sel ? SIZE_MSK : SIZE_NIB;
    if (mode_sel) base = map_word & ~(size - 32'd1);
    else          base = {map_word[3:0], 28'h0};
    addr = base + off;
    oor  = (off >= size);
  end
endmodule

// File: rtl/pci_win_map.sv
module pci_win_map
  import pci_win_map_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [NWIN-1:0][31:0] SIZES_NIB = {32'h1000_0000, 32'h1000_0000, 32'h0C00_0000},
  parameter logic [NWIN-1:0][31:0] SIZES_MSK = {32'h0800_0000, 32'h0400_0000, 32'h0100_0000}
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  mode_sel,
  input  logic                  reg_wr,
  input  logic                  reg_rd,
  input  logic [ADDR_W-1:0]     reg_addr,
  input  logic [31:0]           reg_wdata,
  output logic [31:0]           reg_rdata,
  output logic                  reg_rvalid,
  input  logic [NWIN-1:0][31:0] win_off,
  output logic [NWIN-1:0][31:0] win_addr,
  output logic [NWIN-1:0]       win_oor
);
  logic [NWIN-1:0][31:0] map_q;
  dec_t wdec;

  always_comb wdec = decode_off(32'(reg_addr));

  pci_win_regbank #(.ADDR_W(ADDR_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .rd(reg_rd), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .rvalid(reg_rvalid), .map_q(map_q)
  );

  for (genvar w = 0; w < NWIN; w++) begin : g_win
    pci_win_xlate #(.SIZE_NIB(SIZES_NIB[w]), .SIZE_MSK(SIZES_MSK[w])) u_xl (
      .mode_sel(mode_sel), .map_word(map_q[w]), .off(win_off[w]),
      .addr(win_addr[w]), .oor(win_oor[w])
    );

    // R5
    nib_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_sel && !win_oor[w]) |-> (win_addr[w][31:28] == map_q[w][3:0]));

    if ($countones(SIZES_MSK[w]) == 1) begin : g_pow2
      // R6
      msk_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel && !win_oor[w]) |->
          ((win_addr[w] & ~(SIZES_MSK[w] - 32'd1)) == (map_q[w] & ~(SIZES_MSK[w] - 32'd1))));
    end
  end

  // R8
  side_write_inert_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && wdec.hit && (int'(wdec.idx) >= IDX_SELF)) |=>
      (!$stable(win_off) || $stable(win_addr)));
endmodule

// File: tb/pci_win_map_tb.sv
module pci_win_map_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_sel = 1'b0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic reg_rvalid;
  logic [2:0][31:0] win_off = '0;
  logic [2:0][31:0] win_addr;
  logic [2:0] win_oor;

  int vectors = 0, miscompares = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pci_win_map u_dut (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .reg_rvalid(reg_rvalid), .win_off(win_off), .win_addr(win_addr), .win_oor(win_oor)
  );

  // behavioural model
  logic [31:0] m_word [8];
  logic [31:0] m_rdata;
  logic        m_rvalid;
  logic [31:0] sz_nib [3] = '{32'h0C00_0000, 32'h1000_0000, 32'h1000_0000};
  logic [31:0] sz_msk [3] = '{32'h0100_0000, 32'h0400_0000, 32'h0800_0000};

  function automatic logic [31:0] m_read(input logic [7:0] a);
    if (a[1:0] != 0 || a >= 8'h20) return 32'h0;
    return m_word[a >> 2];
  endfunction

  task automatic m_reset();
    foreach (m_word[k]) m_word[k] = 32'h0;
    m_rdata = 0; m_rvalid = 0;
  endtask

  task automatic expect_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    expect_eq("R3 rvalid", {31'h0, reg_rvalid}, {31'h0, m_rvalid});
    expect_eq("R2 rdata", reg_rdata, m_rdata);
    for (int w = 0; w < 3; w++) begin
      logic [31:0] sz, base;
      sz = mode_sel ? sz_msk[w] : sz_nib[w];
      base = mode_sel ? (m_word[w] & ~(sz - 1)) : (m_word[w] & 32'hF) << 28;
      expect_eq("R7 oor", {31'h0, win_oor[w]}, {31'h0, (win_off[w] >= sz)});
      if (win_off[w] < sz)
        expect_eq(mode_sel ? "R6 addr" : "R5 addr", win_addr[w], base + win_off[w]);
    end
  endtask

  // one cycle: drive at negedge, model at posedge, compare at next negedge
  task automatic cyc(input logic wr, input logic rd, input logic [7:0] a, input logic [31:0] d);
    reg_wr = wr; reg_rd = rd; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    m_rvalid = rd;
    if (rd) m_rdata = m_read(a);        // R9: read sees pre-write value
    if (wr && a[1:0] == 0 && a < 8'h20) m_word[a >> 2] = d;
    @(negedge clk);
    reg_wr = 0; reg_rd = 0;
    compare_all();
  endtask

  task automatic do_reset(input logic m);
    rst_n = 0; mode_sel = m;
    reg_wr = 0; reg_rd = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    m_reset();
    compare_all();   // R1 reset state
  endtask

  task automatic set_offs(input logic [31:0] a, input logic [31:0] b, input logic [31:0] c);
    win_off[0] = a; win_off[1] = b; win_off[2] = c;
  endtask

  logic [7:0] alist [11] = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h10, 8'h14, 8'h18, 8'h1C, 8'h20, 8'h02, 8'hFC};

  task automatic phase(input logic m);
    do_reset(m);
    set_offs(32'h123, 32'h0, 32'h456);
    // R1 reset reads of every word
    for (int k = 0; k < 8; k++) cyc(0, 1, 8'(k * 4), 0);
    // R2 write/read back
    for (int k = 0; k < 8; k++) cyc(1, 0, 8'(k * 4), 32'hA5A5_0000 ^ (32'(k) * 32'h1111_1111) ^ 32'h7);
    for (int k = 0; k < 8; k++) cyc(0, 1, 8'(k * 4), 0);
    // R4 undefined offsets: write then read everything
    cyc(1, 0, 8'h20, 32'hFFFF_FFFF);
    cyc(1, 0, 8'h01, 32'hFFFF_FFFF);
    cyc(1, 0, 8'h16, 32'hDEAD_BEEF);
    cyc(0, 1, 8'h22, 0);
    cyc(0, 1, 8'h03, 0);
    for (int k = 0; k < 8; k++) cyc(0, 1, 8'(k * 4), 0);
    // R8 map write affects next cycle; side writes inert
    cyc(1, 0, 8'h00, 32'h7654_3219);
    cyc(1, 0, 8'h14, 32'h0);
    cyc(1, 0, 8'h0C, 32'h1);
    cyc(1, 0, 8'h10, 32'h2);
    // R7 boundary offsets: size-1 and size
    for (int w = 0; w < 3; w++) begin
      logic [31:0] sz;
      sz = m ? sz_msk[w] : sz_nib[w];
      win_off[w] = sz - 1; cyc(0, 0, 0, 0);
      win_off[w] = sz;     cyc(0, 0, 0, 0);
      win_off[w] = 32'hFFFF_FFFF; cyc(0, 0, 0, 0);
      win_off[w] = 0;      cyc(0, 0, 0, 0);
    end
    // R9 simultaneous read and write
    cyc(1, 1, 8'h08, 32'hCAFE_F00D);
    cyc(0, 1, 8'h08, 0);
    // mixed random traffic, R5/R6 under many map values
    for (int n = 0; n < 400; n++) begin
      logic [31:0] sz;
      for (int w = 0; w < 3; w++) begin
        sz = m ? sz_msk[w] : sz_nib[w];
        win_off[w] = ($urandom % 4 == 0) ? sz - 32'($urandom % 3) : $urandom % sz;
      end
      cyc(1'($urandom), 1'($urandom), alist[$urandom % 11], $urandom);
    end
  endtask

  initial begin
    m_reset();
    @(negedge clk);
    phase(1'b0);
    phase(1'b1);
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule